// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Control Core

A compact accumulator processor core whose control is entirely hardwired. A 2-bit phase register and a per-phase step counter are decoded each clock into a set of register-transfer enables that move values between the memory address register, the memory buffer register, the program counter, the instruction register and a single accumulator. Every instruction passes through a fetch phase. It then takes an optional indirect phase and an execute phase. After the execute phase it may take an interrupt phase.

The core drives a synchronous single-port memory with an address, write data, a read strobe and a write strobe. Read data comes back on the clock after the strobe. Three operations are executed: accumulate from memory, increment-memory-and-skip-on-zero, and branch-with-return-link. An interrupt request is honoured between instructions when the enable flag is set. The return address is stored in a fixed memory slot and control moves to a fixed service entry.

Top module: `insn_core`

## Requirements
- R1: While reset is asserted and before the first instruction completes, pc_o = 0, acc_o = 0, phase_o = 2'b00 and step_o = 0. Interrupts stay disabled until irq_en_set_i is pulsed.
- R2: phase_o encodes the phase as 2'b00 fetch, 2'b01 indirect, 2'b10 execute, 2'b11 interrupt. step_o counts from 0 within a phase and is 0 in the first cycle of every phase.
- R3: Fetch lasts 3 cycles. It reads the word at PC and increments PC once. The word's bits [15:12] are the opcode, bit 11 is the indirect flag and bits [10:0] are the address. The next phase is indirect when bit 11 is set, and execute otherwise.
- R4: Indirect lasts 3 cycles. It reads the word at the address field and replaces the address field with bits [10:0] of that word. Execute follows.
- R5: Opcode 0 (accumulate) lasts 3 execute cycles and sets acc = acc + mem[addr] modulo 2^16.
- R6: Opcode 1 (increment-skip) lasts 4 execute cycles and writes mem[addr] + 1 back to memory. When the written value is 0, PC is incremented once more.
- R7: Opcode 2 (branch-link) lasts 3 execute cycles. It stores the address of the next instruction into mem[addr], and execution continues at addr + 1.
- R8: Any other opcode takes a single execute cycle and changes neither PC, acc nor memory.
- R9: The interrupt phase follows an execute phase only when irq_i is high and the enable flag is set. It lasts 3 cycles, writes the return PC to address 0, and then fetch resumes at address 1.
- R10: The enable flag is set by a pulse on irq_en_set_i and is cleared when the interrupt phase is entered, so a request that is held high is not taken again.
- R11: Memory reads and writes are never strobed in the same cycle. On a read cycle mem_addr_o carries the address being loaded into the address register, and the data is taken on the next cycle. On a write cycle mem_addr_o is the held address register and mem_wdata_o is the buffer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request level |
| irq_en_set_i | input | 1 | Pulse to set the interrupt enable flag |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after mem_rd_o |
| mem_addr_o | output | 11 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| pc_o | output | 11 | Program counter |
| acc_o | output | 16 | Accumulator |
| phase_o | output | 2 | Current phase |
| step_o | output | 2 | Step within the phase |

## Verification
The bench targets the following corner cases:
- An accumulate through an indirect pointer whose sum wraps to zero. A core that fails to rewrite the address field adds the pointer instead of the operand.
- An increment-skip on 0xFFFF. A design that tests the zero condition before the increment, or skips on every increment, leaves PC one word off. A skipped accumulate that runs anyway changes acc.
- An indirect branch-link. A design that saves the wrong PC corrupts the return slot, and one that omits the final increment lands on the link word.
- An interrupt request held high through disabled instructions, then through an enable. A design that ignores the enable takes the interrupt too early. One that does not clear the flag on entry re-enters the service routine instead of executing it. Cycle counts and the set of phases seen per instruction expose any wrong step count or wrong phase order.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int STEP_W = 2;
  localparam int OPC_W  = 4;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_INDIR = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;

  localparam logic [OPC_W-1:0] OP_ACC  = 4'h0;
  localparam logic [OPC_W-1:0] OP_INCS = 4'h1;
  localparam logic [OPC_W-1:0] OP_LINK = 4'h2;

  // one enable per register transfer
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_from_save;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic mbr_inc;
    logic pc_inc;
    logic pc_from_ir;
    logic pc_from_isr;
    logic pc_skip_zero;
    logic ir_load;
    logic ir_addr_from_mbr;
    logic acc_add;
    logic mem_rd;
    logic mem_wr;
    logic last_step;
  } ctrl_t;

endpackage

// File: rtl/cycle_seq.sv
module cycle_seq
  import core_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_step_i,
  input  logic              ind_flag_i,
  input  logic              irq_i,
  input  logic              irq_en_set_i,
  output phase_e            phase_o,
  output logic [STEP_W-1:0] step_o,
  output logic              irq_en_o
);

  phase_e            phase_q, phase_d;
  logic [STEP_W-1:0] step_q;
  logic              ie_q;
  logic              take_irq;

  assign take_irq = irq_i && ie_q;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_FETCH: phase_d = ind_flag_i ? PH_INDIR : PH_EXEC;
      PH_INDIR: phase_d = PH_EXEC;
      PH_EXEC:  phase_d = take_irq ? PH_INTR : PH_FETCH;
      default:  phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      step_q  <= '0;
    end else if (last_step_i) begin
      phase_q <= phase_d;
      step_q  <= '0;
    end else begin
      step_q  <= step_q + 1'b1;
    end
  end

  // entry clear wins over a coincident set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0;
    end else if (last_step_i && phase_q == PH_EXEC && take_irq) begin
      ie_q <= 1'b0;
    end else if (irq_en_set_i) begin
      ie_q <= 1'b1;
    end
  end

  assign phase_o  = phase_q;
  assign step_o   = step_q;
  assign irq_en_o = ie_q;

endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import core_pkg::*;
(
  input  phase_e            phase_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [OPC_W-1:0]  opcode_i,
  output ctrl_t             ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    case (phase_i)
      PH_FETCH: begin
        case (step_i)
          2'd0: begin ctrl_o.mar_from_pc = 1'b1; ctrl_o.mem_rd = 1'b1; end
          2'd1: begin ctrl_o.mbr_from_mem = 1'b1; ctrl_o.pc_inc = 1'b1; end
          default: begin ctrl_o.ir_load = 1'b1; ctrl_o.last_step = 1'b1; end
        endcase
      end
      PH_INDIR: begin
        case (step_i)
          2'd0: begin ctrl_o.mar_from_ir = 1'b1; ctrl_o.mem_rd = 1'b1; end
          2'd1: ctrl_o.mbr_from_mem = 1'b1;
          default: begin ctrl_o.ir_addr_from_mbr = 1'b1; ctrl_o.last_step = 1'b1; end
        endcase
      end
      PH_EXEC: begin
        case (opcode_i)
          OP_ACC: begin
            case (step_i)
              2'd0: begin ctrl_o.mar_from_ir = 1'b1; ctrl_o.mem_rd = 1'b1; end
              2'd1: ctrl_o.mbr_from_mem = 1'b1;
              default: begin ctrl_o.acc_add = 1'b1; ctrl_o.last_step = 1'b1; end
            endcase
          end
          OP_INCS: begin
            case (step_i)
              2'd0: begin ctrl_o.mar_from_ir = 1'b1; ctrl_o.mem_rd = 1'b1; end
              2'd1: ctrl_o.mbr_from_mem = 1'b1;
              2'd2: ctrl_o.mbr_inc = 1'b1;
              default: begin
                ctrl_o.mem_wr       = 1'b1;
                ctrl_o.pc_skip_zero = 1'b1;
                ctrl_o.last_step    = 1'b1;
              end
            endcase
          end
          OP_LINK: begin
            case (step_i)
              2'd0: begin ctrl_o.mar_from_ir = 1'b1; ctrl_o.mbr_from_pc = 1'b1; end
              2'd1: begin ctrl_o.pc_from_ir = 1'b1; ctrl_o.mem_wr = 1'b1; end
              default: begin ctrl_o.pc_inc = 1'b1; ctrl_o.last_step = 1'b1; end
            endcase
          end
          default: ctrl_o.last_step = 1'b1;
        endcase
      end
      default: begin
        case (step_i)
          2'd0: ctrl_o.mbr_from_pc = 1'b1;
          2'd1: begin ctrl_o.mar_from_save = 1'b1; ctrl_o.pc_from_isr = 1'b1; end
          default: begin ctrl_o.mem_wr = 1'b1; ctrl_o.last_step = 1'b1; end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/core_datapath.sv
module core_datapath
  import core_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 11,
  parameter int SAVE_ADDR = 0,
  parameter int ISR_ADDR  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              ind_flag_o
);

  localparam int IND_BIT = DATA_W - OPC_W - 1;
  localparam int PAD_W   = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] mar_q, mar_d, pc_q;
  logic [DATA_W-1:0] mbr_q, ir_q, acc_q;
  logic              mar_load;

  assign mar_load = ctrl_i.mar_from_pc | ctrl_i.mar_from_ir | ctrl_i.mar_from_save;

  always_comb begin
    mar_d = mar_q;
    if (ctrl_i.mar_from_pc)        mar_d = pc_q;
    else if (ctrl_i.mar_from_ir)   mar_d = ir_q[ADDR_W-1:0];
    else if (ctrl_i.mar_from_save) mar_d = ADDR_W'(SAVE_ADDR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mar_q <= '0;
    else if (mar_load) mar_q <= mar_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbr_q <= '0;
    end else if (ctrl_i.mbr_from_mem) begin
      mbr_q <= mem_rdata_i;
    end else if (ctrl_i.mbr_from_pc) begin
      mbr_q <= {{PAD_W{1'b0}}, pc_q};
    end else if (ctrl_i.mbr_inc) begin
      mbr_q <= mbr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (ctrl_i.pc_from_ir) begin
      pc_q <= ir_q[ADDR_W-1:0];
    end else if (ctrl_i.pc_from_isr) begin
      pc_q <= ADDR_W'(ISR_ADDR);
    end else if (ctrl_i.pc_inc || (ctrl_i.pc_skip_zero && mbr_q == '0)) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0;
    end else if (ctrl_i.ir_load) begin
      ir_q <= mbr_q;
    end else if (ctrl_i.ir_addr_from_mbr) begin
      ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (ctrl_i.acc_add) acc_q <= acc_q + mbr_q;
  end

  // read address bypasses MAR so data lands one step later
  assign mem_addr_o  = ctrl_i.mem_rd ? mar_d : mar_q;
  assign mem_wdata_o = mbr_q;
  assign pc_o        = pc_q;
  assign acc_o       = acc_q;
  assign opcode_o    = ir_q[DATA_W-1 -: OPC_W];
  assign ind_flag_o  = mbr_q[IND_BIT];

endmodule

// File: rtl/insn_core.sv
module insn_core
  import core_pkg::*;
#(
  parameter  int DATA_W    = 16,
  parameter  int SAVE_ADDR = 0,
  parameter  int ISR_ADDR  = 1,
  localparam int ADDR_W    = DATA_W - OPC_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              irq_en_set_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [1:0]        phase_o,
  output logic [STEP_W-1:0] step_o
);

  ctrl_t             ctrl;
  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic [OPC_W-1:0]  opcode;
  logic              ind_flag;
  logic              irq_en;

  cycle_seq i_cycle_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .last_step_i  (ctrl.last_step),
    .ind_flag_i   (ind_flag),
    .irq_i        (irq_i),
    .irq_en_set_i (irq_en_set_i),
    .phase_o      (phase),
    .step_o       (step),
    .irq_en_o     (irq_en)
  );

  ctrl_decode i_ctrl_decode (
    .phase_i  (phase),
    .step_i   (step),
    .opcode_i (opcode),
    .ctrl_o   (ctrl)
  );

  core_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
  ) i_core_datapath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_o        (pc_o),
    .acc_o       (acc_o),
    .opcode_o    (opcode),
    .ind_flag_o  (ind_flag)
  );

  assign mem_rd_o = ctrl.mem_rd;
  assign mem_wr_o = ctrl.mem_wr;
  assign phase_o  = phase;
  assign step_o   = step;

endmodule

// File: rtl/core_chk.sv
module core_chk #(
  parameter int ADDR_W    = 11,
  parameter int SAVE_ADDR = 0,
  parameter int ISR_ADDR  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        phase_o,
  input logic [1:0]        step_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              irq_i,
  input logic              irq_en
);

  // R11
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R2
  step_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_o) |-> step_o == 2'd0);

  // R3
  fetch_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b00 && step_o == 2'd2) |=>
      ((phase_o == 2'b01 || phase_o == 2'b10) && step_o == 2'd0));

  // R9
  intr_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b11 && step_o == 2'd0) |->
      ($past(phase_o) == 2'b10 && $past(irq_en) && $past(irq_i)));

  // R9
  intr_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b11 && step_o == 2'd1) |=> pc_o == ADDR_W'(ISR_ADDR));

  // R9
  intr_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b11 && step_o == 2'd2) |->
      (mem_wr_o && mem_addr_o == ADDR_W'(SAVE_ADDR)));

  // R10
  en_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b11 && step_o == 2'd0) |-> !irq_en);

endmodule

bind insn_core core_chk #(
  .ADDR_W    (ADDR_W),
  .SAVE_ADDR (SAVE_ADDR),
  .ISR_ADDR  (ISR_ADDR)
) i_core_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_o    (phase_o),
  .step_o     (step_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o),
  .pc_o       (pc_o),
  .irq_i      (irq_i),
  .irq_en     (irq_en)
);

// File: tb/test_insn_core.sv
module test_insn_core;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_i = 1'b0;
  logic        irq_en_set_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic [10:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_rd_o, mem_wr_o;
  logic [10:0] pc_o;
  logic [15:0] acc_o;
  logic [1:0]  phase_o, step_o;

  logic [15:0] mem [0:2047];
  int n_vec = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  insn_core i_insn_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_i        (irq_i),
    .irq_en_set_i (irq_en_set_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .pc_o         (pc_o),
    .acc_o        (acc_o),
    .phase_o      (phase_o),
    .step_o       (step_o)
  );

  // synchronous memory, read data one cycle after strobe
  always @(posedge clk_i) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  // {phase mask, cycles, pc, acc}
  localparam logic [47:0] VECS [9] = '{
    48'h05_06_0001_0005,  // R5 plain accumulate
    48'h05_06_0002_000C,  // R5
    48'h07_09_0003_0000,  // R4 R5 indirect, wrap to zero
    48'h05_07_0004_0000,  // R6 no skip
    48'h05_07_0006_0000,  // R6 skip
    48'h05_06_0201_0000,  // R7 direct link
    48'h05_06_0202_0005,  // R5 at target+1
    48'h07_09_0301_0005,  // R7 indirect link
    48'h05_04_0302_0005   // R8 unknown opcode
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_insn(output int cyc, output logic [7:0] mask);
    cyc  = 0;
    mask = 8'h00;
    do begin
      @(negedge clk_i);
      cyc++;
      mask = mask | (8'h01 << phase_o);
    end while (!(phase_o == 2'b00 && step_o == 2'b00) && cyc < 100);
  endtask

  task automatic check_insn(input string tag, input logic [47:0] v);
    int         cyc;
    logic [7:0] mask;
    run_insn(cyc, mask);
    chk({tag, " phases R2"}, 32'(mask), 32'(v[47:40]));
    chk({tag, " cycles R3"}, cyc, 32'(v[39:32]));
    chk({tag, " pc"}, 32'(pc_o), 32'(v[31:16]));
    chk({tag, " acc"}, 32'(acc_o), 32'(v[15:0]));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog all-reqs actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    mem[11'h000] = 16'h0100;  // acc  0x100
    mem[11'h001] = 16'h0101;  // acc  0x101
    mem[11'h002] = 16'h0902;  // acc  @0x102
    mem[11'h003] = 16'h1104;  // incs 0x104
    mem[11'h004] = 16'h1105;  // incs 0x105 -> skip
    mem[11'h005] = 16'h0100;  // skipped
    mem[11'h006] = 16'h2200;  // link 0x200
    mem[11'h201] = 16'h0100;
    mem[11'h202] = 16'h2906;  // link @0x106
    mem[11'h301] = 16'hF000;  // unknown opcode
    mem[11'h302] = 16'h0100;
    mem[11'h303] = 16'h0100;
    mem[11'h100] = 16'h0005;
    mem[11'h101] = 16'h0007;
    mem[11'h102] = 16'h0103;
    mem[11'h103] = 16'hFFF4;
    mem[11'h104] = 16'h0005;
    mem[11'h105] = 16'hFFFF;
    mem[11'h106] = 16'h0300;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 pc", 32'(pc_o), 32'h0);
    chk("R1 acc", 32'(acc_o), 32'h0);
    chk("R1 phase", 32'(phase_o), 32'h0);
    chk("R1 step", 32'(step_o), 32'h0);
    rst_ni = 1'b1;
    // R11 first read issued with address PC
    chk("R11 rd strobe", 32'(mem_rd_o), 32'h1);
    chk("R11 rd addr", 32'(mem_addr_o), 32'h0);

    foreach (VECS[i]) check_insn($sformatf("vec%0d", i), VECS[i]);

    chk("R6 no-skip write", 32'(mem[11'h104]), 32'h0006);
    chk("R6 skip write", 32'(mem[11'h105]), 32'h0000);
    chk("R7 link word", 32'(mem[11'h200]), 32'h0007);
    chk("R7 indirect link word", 32'(mem[11'h300]), 32'h0203);

    // R10 request held while disabled is ignored
    irq_i = 1'b1;
    check_insn("R9 disabled", 48'h05_06_0303_000A);
    chk("R9 save slot untouched", 32'(mem[11'h000]), 32'h0100);

    // R10 enable then take interrupt after execute
    irq_en_set_i = 1'b1;
    @(negedge clk_i);
    irq_en_set_i = 1'b0;
    begin
      int         cyc;
      logic [7:0] mask;
      run_insn(cyc, mask);
      chk("R9 phases", 32'(mask), 32'h0D);
      chk("R9 cycles", cyc + 1, 32'd9);
      chk("R9 pc to service", 32'(pc_o), 32'h1);
      chk("R9 acc", 32'(acc_o), 32'h000F);
      chk("R9 return saved", 32'(mem[11'h000]), 32'h0304);
    end

    // R10 held request not retaken
    check_insn("R10 no reentry", 48'h05_06_0002_0016);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule